// File: doc/BRIEF.md
# Restartable Rectangle Blit Sequencer

This block runs a rectangular copy-and-combine pass between two bitmaps that store four bits per pixel. It takes a description of each bitmap and of the rectangle, and rejects the job before any memory access if the parameters are inconsistent. For each line of the rectangle it reads source and destination words through one word-wide memory port. It hands each source/destination pixel pair to an external combine unit, puts the returned pixel back into the destination word, and writes that word when it is complete. The combine function itself lives outside the block. The sequencer supplies the two input pixels and a two-bit texture phase, and it takes back one 4-bit result in the same cycle.

Lines are handled from the last line of the rectangle toward the first. Between lines, a pending interrupt suspends the job. A fault reported by memory also suspends it, even in the middle of a line. After a suspension, the job can be resumed using only two reported values, the remaining line count and the remaining pixel count of the current line, together with the original parameters.

Top module: `blit_seq`

## Requirements
- R1: A start pulse is taken only while `busy` is low: the parameters are captured on that cycle and `busy` rises on the next one. A start pulse while busy has no effect on the transfer.
- R2: A transfer is rejected when either bitmap's bits-per-pixel field is not 4. Rejection produces a one-cycle `error` pulse and no memory access.
- R3: A transfer is rejected, as in R2, when, for either bitmap, y >= height, y + transfer height > height, x >= width_bits/4, or x + transfer width > width_bits/4.
- R4: A transfer is rejected, as in R2, when the transfer height is 0, the transfer width is 0, or the resume width exceeds the transfer width.
- R5: The word address of line position L (L = lines still to do, counting down from the transfer height to 1) and pixel column X is base + (height − (y + L)) × raster_words + X / P, where P = WORD_W/4.
- R6: Pixel X of a line occupies bits [WORD_W−1−4·(X mod P) −: 4] of its word, so the leftmost pixel sits in the most significant nibble.
- R7: Every destination pixel in the rectangle is replaced by `cmb_result`. The values presented are `cmb_src` and `cmb_dst` for that pixel, and `cmb_phase` = {LSB of (dst_y + L − 1), LSB of the destination X}. Pixels outside the rectangle keep their memory contents.
- R8: A resume width of 0 starts a fresh transfer. A nonzero resume width r starts the first processed line at column offset (transfer width − r), with r pixels to do; every later line starts at offset 0.
- R9: After the last pixel of a line, the partly filled destination word is written. When the line count reaches 0, `done` pulses for one cycle and `lines_left` reads 0.
- R10: If `irq` is high when a line finishes and lines remain, the block suspends. `suspended` pulses, `lines_left` holds the lines still to do, and `resume_width` is 0.
- R11: A `mem_fault` response ends the transfer at once. `suspended` pulses, `lines_left` holds the current line count, and `resume_width` holds the number of pixels of the current line that have not yet been written to memory. No further request follows.
- R12: A memory request keeps `mem_req`, `mem_we` and `mem_addr` unchanged until `mem_ack` or `mem_fault` is seen.
- R13: At most one of `done`, `error` and `suspended` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; parameters captured when idle |
| src_base | input | ADDR_W | Word address of source upper-left corner |
| src_raster | input | DIM_W | Source words per line |
| src_height | input | DIM_W | Source height in lines |
| src_width_bits | input | DIM_W+2 | Source width in bits |
| src_bpp | input | 4 | Source bits per pixel |
| dst_base | input | ADDR_W | Word address of destination upper-left corner |
| dst_raster | input | DIM_W | Destination words per line |
| dst_height | input | DIM_W | Destination height in lines |
| dst_width_bits | input | DIM_W+2 | Destination width in bits |
| dst_bpp | input | 4 | Destination bits per pixel |
| src_x | input | DIM_W | Source rectangle column |
| src_y | input | DIM_W | Source rectangle y |
| dst_x | input | DIM_W | Destination rectangle column |
| dst_y | input | DIM_W | Destination rectangle y |
| xfer_w | input | DIM_W | Transfer width in pixels |
| xfer_h | input | DIM_W | Transfer height in lines |
| resume_w | input | DIM_W | Pixels left in partial line, 0 for a fresh start |
| irq | input | 1 | Interrupt request, sampled between lines |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | WORD_W | Write data |
| mem_ack | input | 1 | Request completed |
| mem_fault | input | 1 | Request faulted |
| mem_rdata | input | WORD_W | Read data, valid with mem_ack |
| cmb_src | output | 4 | Source pixel to combine unit |
| cmb_dst | output | 4 | Destination pixel to combine unit |
| cmb_phase | output | 2 | Texture phase {y parity, x parity} |
| cmb_result | input | 4 | New destination pixel |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Normal completion pulse |
| error | output | 1 | Rejection pulse |
| suspended | output | 1 | Suspension pulse |
| lines_left | output | DIM_W | Lines still to process |
| resume_width | output | DIM_W | Pixel count for resuming |

## Verification
The bench builds the block with ADDR_W = 12, DIM_W = 8 and WORD_W = 16, so each word holds four pixels. Both bitmaps are 16 pixels wide and 8 lines tall. At this size a full-bitmap transfer, a single pixel in the far corner, and each bound violation are all cheap to reach. So are rectangles that start and end at every nibble position inside a word. A golden image is built from the address and phase rules alone and compared word by word. The bench also forces a fault on a chosen destination write and holds an interrupt high across a line end. It then resumes from the reported counts and checks that the final image matches an uninterrupted run.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int NIB_W = 4;
  localparam logic [3:0] BPP_OK = 4'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SETUP,
    ST_RD_SRC,
    ST_RD_DST,
    ST_MERGE,
    ST_WR_DST,
    ST_LINE_END
  } blit_state_e;
endpackage

// File: rtl/blit_param_check.sv
module blit_param_check #(
  parameter int DIM_W = 12
) (
  input  logic [DIM_W-1:0] s_height,
  input  logic [DIM_W+1:0] s_wbits,
  input  logic [3:0]       s_bpp,
  input  logic [DIM_W-1:0] d_height,
  input  logic [DIM_W+1:0] d_wbits,
  input  logic [3:0]       d_bpp,
  input  logic [DIM_W-1:0] sx,
  input  logic [DIM_W-1:0] sy,
  input  logic [DIM_W-1:0] dx,
  input  logic [DIM_W-1:0] dy,
  input  logic [DIM_W-1:0] w,
  input  logic [DIM_W-1:0] h,
  input  logic [DIM_W-1:0] rs,
  output logic             ok
);
  import blit_pkg::*;

  // pos must be inside limit and pos+len must not pass it
  function automatic logic span_fits(input logic [DIM_W-1:0] pos,
                                     input logic [DIM_W-1:0] len,
                                     input logic [DIM_W:0]   lim);
    logic [DIM_W:0] tail;
    tail = {1'b0, pos} + {1'b0, len};
    return ({1'b0, pos} < lim) && (tail <= lim);
  endfunction

  logic [DIM_W:0] s_px, d_px;
  logic           fmt_ok, size_ok, src_ok, dst_ok;

  always_comb begin
    s_px    = s_wbits[DIM_W+1:2];
    d_px    = d_wbits[DIM_W+1:2];
    fmt_ok  = (s_bpp == BPP_OK) && (d_bpp == BPP_OK);
    size_ok = (h != '0) && (w != '0) && (rs <= w);
    src_ok  = span_fits(sy, h, {1'b0, s_height}) && span_fits(sx, w, s_px);
    dst_ok  = span_fits(dy, h, {1'b0, d_height}) && span_fits(dx, w, d_px);
    ok      = fmt_ok && size_ok && src_ok && dst_ok;
  end
endmodule

// File: rtl/blit_line_addr.sv
module blit_line_addr #(
  parameter int ADDR_W = 20,
  parameter int DIM_W  = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DIM_W-1:0]  raster,
  input  logic [DIM_W-1:0]  height,
  input  logic [DIM_W-1:0]  y,
  input  logic [DIM_W-1:0]  lines,
  output logic [ADDR_W-1:0] line_addr
);
  localparam int PROD_W = 2 * DIM_W + 2;

  logic [DIM_W:0]  top_line;
  logic [DIM_W:0]  row;
  logic [PROD_W-1:0] prod;

  always_comb begin
    top_line  = {1'b0, y} + {1'b0, lines};
    row       = {1'b0, height} - top_line;
    prod      = row * {1'b0, raster};
    line_addr = base + ADDR_W'(prod);
  end
endmodule

// File: rtl/blit_nib_pick.sv
module blit_nib_pick #(
  parameter int WORD_W = 16,
  parameter int SEL_W  = $clog2(WORD_W / 4)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [3:0]        nib_o
);
  localparam int LANES = WORD_W / 4;

  logic [3:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[WORD_W-1-4*g -: 4];
  end

  assign nib_o = lane[sel_i];
endmodule

// File: rtl/blit_nib_put.sv
module blit_nib_put #(
  parameter int WORD_W = 16,
  parameter int SEL_W  = $clog2(WORD_W / 4)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [3:0]        nib_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int LANES = WORD_W / 4;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_o[WORD_W-1-4*g -: 4] =
      (sel_i == SEL_W'(g)) ? nib_i : word_i[WORD_W-1-4*g -: 4];
  end
endmodule

// File: rtl/blit_seq.sv
module blit_seq #(
  parameter int ADDR_W = 20,
  parameter int DIM_W  = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [DIM_W-1:0]  src_raster,
  input  logic [DIM_W-1:0]  src_height,
  input  logic [DIM_W+1:0]  src_width_bits,
  input  logic [3:0]        src_bpp,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [DIM_W-1:0]  dst_raster,
  input  logic [DIM_W-1:0]  dst_height,
  input  logic [DIM_W+1:0]  dst_width_bits,
  input  logic [3:0]        dst_bpp,
  input  logic [DIM_W-1:0]  src_x,
  input  logic [DIM_W-1:0]  src_y,
  input  logic [DIM_W-1:0]  dst_x,
  input  logic [DIM_W-1:0]  dst_y,
  input  logic [DIM_W-1:0]  xfer_w,
  input  logic [DIM_W-1:0]  xfer_h,
  input  logic [DIM_W-1:0]  resume_w,
  input  logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_fault,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [3:0]        cmb_src,
  output logic [3:0]        cmb_dst,
  output logic [1:0]        cmb_phase,
  input  logic [3:0]        cmb_result,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              suspended,
  output logic [DIM_W-1:0]  lines_left,
  output logic [DIM_W-1:0]  resume_width
);
  import blit_pkg::*;

  localparam int PPW   = WORD_W / NIB_W;
  localparam int SUB_W = $clog2(PPW);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PPW - 1);

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [DIM_W-1:0]  raster;
    logic [DIM_W-1:0]  height;
    logic [DIM_W+1:0]  wbits;
    logic [3:0]        bpp;
  } bmp_t;

  typedef struct packed {
    logic [DIM_W-1:0] sx, sy, dx, dy, w, h, rs;
  } xfer_t;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // captured parameters
  bmp_t  src_q, dst_q;
  xfer_t xf_q;
  logic  prm_en;

  always_ff @(posedge clk) begin
    if (prm_en) begin
      src_q <= '{base: src_base, raster: src_raster, height: src_height,
                 wbits: src_width_bits, bpp: src_bpp};
      dst_q <= '{base: dst_base, raster: dst_raster, height: dst_height,
                 wbits: dst_width_bits, bpp: dst_bpp};
      xf_q  <= '{sx: src_x, sy: src_y, dx: dst_x, dy: dst_y,
                 w: xfer_w, h: xfer_h, rs: resume_w};
    end
  end

  // state
  blit_state_e       st_q, st_d;
  logic [DIM_W-1:0]  lines_q, lines_d;
  logic [DIM_W-1:0]  cnt_q, cnt_d;
  logic [DIM_W-1:0]  cnt_word_q, cnt_word_d;
  logic [DIM_W-1:0]  xoff_q, xoff_d;
  logic [DIM_W-1:0]  sx_q, sx_d, dx_q, dx_d;
  logic [ADDR_W-1:0] s_line_q, s_line_d, d_line_q, d_line_d;
  logic [ADDR_W-1:0] d_addr_q, d_addr_d;
  logic [WORD_W-1:0] s_word_q, s_word_d, d_word_q, d_word_d;
  logic              s_vld_q, s_vld_d, d_vld_q, d_vld_d;
  logic              done_q, done_d, err_q, err_d, susp_q, susp_d;
  logic [DIM_W-1:0]  resume_q, resume_d;

  // helpers
  logic              prm_ok;
  logic [ADDR_W-1:0] s_line_calc, d_line_calc;
  logic [ADDR_W-1:0] s_cur_addr, d_cur_addr;
  logic [WORD_W-1:0] d_word_merged;
  logic [DIM_W-1:0]  resume_on_fault;

  blit_param_check #(.DIM_W(DIM_W)) u_check (
    .s_height (src_q.height), .s_wbits (src_q.wbits), .s_bpp (src_q.bpp),
    .d_height (dst_q.height), .d_wbits (dst_q.wbits), .d_bpp (dst_q.bpp),
    .sx (xf_q.sx), .sy (xf_q.sy), .dx (xf_q.dx), .dy (xf_q.dy),
    .w (xf_q.w), .h (xf_q.h), .rs (xf_q.rs),
    .ok (prm_ok)
  );

  blit_line_addr #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_src_line (
    .base (src_q.base), .raster (src_q.raster), .height (src_q.height),
    .y (xf_q.sy), .lines (lines_q), .line_addr (s_line_calc)
  );

  blit_line_addr #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_dst_line (
    .base (dst_q.base), .raster (dst_q.raster), .height (dst_q.height),
    .y (xf_q.dy), .lines (lines_q), .line_addr (d_line_calc)
  );

  blit_nib_pick #(.WORD_W(WORD_W)) u_src_pick (
    .word_i (s_word_q), .sel_i (sx_q[SUB_W-1:0]), .nib_o (cmb_src)
  );

  blit_nib_pick #(.WORD_W(WORD_W)) u_dst_pick (
    .word_i (d_word_q), .sel_i (dx_q[SUB_W-1:0]), .nib_o (cmb_dst)
  );

  blit_nib_put #(.WORD_W(WORD_W)) u_dst_put (
    .word_i (d_word_q), .sel_i (dx_q[SUB_W-1:0]), .nib_i (cmb_result),
    .word_o (d_word_merged)
  );

  assign s_cur_addr      = s_line_q + ADDR_W'(sx_q >> SUB_W);
  assign d_cur_addr      = d_line_q + ADDR_W'(dx_q >> SUB_W);
  assign resume_on_fault = d_vld_q ? cnt_word_q : cnt_q;
  assign cmb_phase       = {~(xf_q.dy[0] ^ lines_q[0]), dx_q[0]};

  // next state
  always_comb begin
    st_d       = st_q;
    lines_d    = lines_q;
    cnt_d      = cnt_q;
    cnt_word_d = cnt_word_q;
    xoff_d     = xoff_q;
    sx_d       = sx_q;
    dx_d       = dx_q;
    s_line_d   = s_line_q;
    d_line_d   = d_line_q;
    d_addr_d   = d_addr_q;
    s_word_d   = s_word_q;
    d_word_d   = d_word_q;
    s_vld_d    = s_vld_q;
    d_vld_d    = d_vld_q;
    resume_d   = resume_q;
    done_d     = 1'b0;
    err_d      = 1'b0;
    susp_d     = 1'b0;
    prm_en     = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = d_word_q;

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          prm_en = 1'b1;
          st_d   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!prm_ok) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          lines_d = xf_q.h;
          cnt_d   = (xf_q.rs != '0) ? xf_q.rs : xf_q.w;
          xoff_d  = (xf_q.rs != '0) ? xf_q.w - xf_q.rs : '0;
          st_d    = ST_SETUP;
        end
      end
      ST_SETUP: begin
        s_line_d = s_line_calc;
        d_line_d = d_line_calc;
        sx_d     = xf_q.sx + xoff_q;
        dx_d     = xf_q.dx + xoff_q;
        xoff_d   = '0;
        s_vld_d  = 1'b0;
        d_vld_d  = 1'b0;
        st_d     = ST_RD_SRC;
      end
      ST_RD_SRC: begin
        if (s_vld_q) begin
          st_d = ST_RD_DST;
        end else begin
          mem_req  = 1'b1;
          mem_addr = s_cur_addr;
          if (mem_fault) begin
            susp_d   = 1'b1;
            resume_d = resume_on_fault;
            st_d     = ST_IDLE;
          end else if (mem_ack) begin
            s_word_d = mem_rdata;
            s_vld_d  = 1'b1;
            st_d     = ST_RD_DST;
          end
        end
      end
      ST_RD_DST: begin
        if (d_vld_q) begin
          st_d = ST_MERGE;
        end else begin
          mem_req  = 1'b1;
          mem_addr = d_cur_addr;
          if (mem_fault) begin
            susp_d   = 1'b1;
            resume_d = resume_on_fault;
            st_d     = ST_IDLE;
          end else if (mem_ack) begin
            d_word_d   = mem_rdata;
            d_vld_d    = 1'b1;
            d_addr_d   = d_cur_addr;
            cnt_word_d = cnt_q;
            st_d       = ST_MERGE;
          end
        end
      end
      ST_MERGE: begin
        d_word_d = d_word_merged;
        cnt_d    = cnt_q - DIM_W'(1);
        sx_d     = sx_q + DIM_W'(1);
        dx_d     = dx_q + DIM_W'(1);
        if (sx_q[SUB_W-1:0] == SUB_LAST) s_vld_d = 1'b0;
        if ((dx_q[SUB_W-1:0] == SUB_LAST) || (cnt_q == DIM_W'(1)))
          st_d = ST_WR_DST;
        else
          st_d = ST_RD_SRC;
      end
      ST_WR_DST: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = d_addr_q;
        if (mem_fault) begin
          susp_d   = 1'b1;
          resume_d = resume_on_fault;
          st_d     = ST_IDLE;
        end else if (mem_ack) begin
          d_vld_d = 1'b0;
          st_d    = (cnt_q == '0) ? ST_LINE_END : ST_RD_SRC;
        end
      end
      ST_LINE_END: begin
        lines_d = lines_q - DIM_W'(1);
        if (lines_q == DIM_W'(1)) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (irq) begin
          susp_d   = 1'b1;
          resume_d = '0;
          st_d     = ST_IDLE;
        end else begin
          cnt_d = xf_q.w;
          st_d  = ST_SETUP;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q       <= ST_IDLE;
      lines_q    <= '0;
      cnt_q      <= '0;
      cnt_word_q <= '0;
      xoff_q     <= '0;
      sx_q       <= '0;
      dx_q       <= '0;
      s_line_q   <= '0;
      d_line_q   <= '0;
      d_addr_q   <= '0;
      s_word_q   <= '0;
      d_word_q   <= '0;
      s_vld_q    <= 1'b0;
      d_vld_q    <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      susp_q     <= 1'b0;
      resume_q   <= '0;
    end else begin
      st_q       <= st_d;
      lines_q    <= lines_d;
      cnt_q      <= cnt_d;
      cnt_word_q <= cnt_word_d;
      xoff_q     <= xoff_d;
      sx_q       <= sx_d;
      dx_q       <= dx_d;
      s_line_q   <= s_line_d;
      d_line_q   <= d_line_d;
      d_addr_q   <= d_addr_d;
      s_word_q   <= s_word_d;
      d_word_q   <= d_word_d;
      s_vld_q    <= s_vld_d;
      d_vld_q    <= d_vld_d;
      done_q     <= done_d;
      err_q      <= err_d;
      susp_q     <= susp_d;
      resume_q   <= resume_d;
    end
  end

  assign busy         = (st_q != ST_IDLE);
  assign done         = done_q;
  assign error        = err_q;
  assign suspended    = susp_q;
  assign lines_left   = lines_q;
  assign resume_width = resume_q;
endmodule

// File: rtl/blit_seq_chk.sv
module blit_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int DIM_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              mem_fault,
  input logic              done,
  input logic              error,
  input logic              suspended,
  input logic [DIM_W-1:0]  lines_left
);
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_fault) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12

  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fault |=> !mem_req); // R11

  AST_DONE_NO_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lines_left == '0)); // R9

  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, error, suspended})); // R13
endmodule

bind blit_seq blit_seq_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_blit_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .mem_fault  (mem_fault),
  .done       (done),
  .error      (error),
  .suspended  (suspended),
  .lines_left (lines_left)
);

// File: tb/test_blit_seq.sv
`timescale 1ns/1ps
module test_blit_seq;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int WW = 16;
  localparam int MEM_N = 1024;
  localparam int SB = 0, DB = 64, SR = 4, DR = 4, SH = 8, DH = 8, WB = 64;

  typedef struct packed {
    logic [7:0] sx, sy, dx, dy, w, h, rs;
    logic       bad;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'd0,  8'd0, 8'd0,  8'd0, 8'd16, 8'd8, 8'd0, 1'b0},  // full bitmap
    '{8'd1,  8'd2, 8'd3,  8'd1, 8'd7,  8'd3, 8'd0, 1'b0},  // misaligned
    '{8'd5,  8'd0, 8'd2,  8'd4, 8'd9,  8'd4, 8'd3, 1'b0},  // resume start
    '{8'd15, 8'd7, 8'd15, 8'd7, 8'd1,  8'd1, 8'd0, 1'b0},  // far corner
    '{8'd10, 8'd0, 8'd0,  8'd0, 8'd7,  8'd1, 8'd0, 1'b1},  // src x overflow
    '{8'd0,  8'd6, 8'd0,  8'd0, 8'd2,  8'd3, 8'd0, 1'b1},  // src y overflow
    '{8'd0,  8'd0, 8'd16, 8'd0, 8'd1,  8'd1, 8'd0, 1'b1},  // dst x outside
    '{8'd0,  8'd0, 8'd0,  8'd0, 8'd4,  8'd0, 8'd0, 1'b1},  // height 0
    '{8'd0,  8'd0, 8'd0,  8'd0, 8'd4,  8'd2, 8'd5, 1'b1},  // resume > width
    '{8'd0,  8'd0, 8'd0,  8'd0, 8'd0,  8'd1, 8'd0, 1'b1}   // width 0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] src_base = AW'(SB), dst_base = AW'(DB);
  logic [DW-1:0] src_raster = DW'(SR), dst_raster = DW'(DR);
  logic [DW-1:0] src_height = DW'(SH), dst_height = DW'(DH);
  logic [DW+1:0] src_width_bits = (DW+2)'(WB), dst_width_bits = (DW+2)'(WB);
  logic [3:0] src_bpp = 4'd4, dst_bpp = 4'd4;
  logic [DW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0;
  logic [DW-1:0] xfer_w = '0, xfer_h = '0, resume_w = '0;
  logic irq = 1'b0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata;
  logic mem_ack = 1'b0, mem_fault = 1'b0;
  logic [WW-1:0] mem_rdata = '0;
  logic [3:0] cmb_src, cmb_dst, cmb_result;
  logic [1:0] cmb_phase;
  logic busy, done, error, suspended;
  logic [DW-1:0] lines_left, resume_width;

  always #4 clk = ~clk;

  function automatic logic [3:0] comb_f(input logic [3:0] s, input logic [3:0] d,
                                        input logic [1:0] ph);
    return s ^ {d[0], d[3:1]} ^ {ph, ~ph};
  endfunction

  assign cmb_result = comb_f(cmb_src, cmb_dst, cmb_phase);

  blit_seq #(.ADDR_W(AW), .DIM_W(DW), .WORD_W(WW)) i_blit_seq (
    .clk, .rst_n, .start,
    .src_base, .src_raster, .src_height, .src_width_bits, .src_bpp,
    .dst_base, .dst_raster, .dst_height, .dst_width_bits, .dst_bpp,
    .src_x, .src_y, .dst_x, .dst_y, .xfer_w, .xfer_h, .resume_w,
    .irq,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_fault, .mem_rdata,
    .cmb_src, .cmb_dst, .cmb_phase, .cmb_result,
    .busy, .done, .error, .suspended, .lines_left, .resume_width
  );

  logic [WW-1:0] mem  [MEM_N];
  logic [WW-1:0] gold [MEM_N];
  int n_checks = 0, n_fail = 0, n_access = 0;
  logic fault_armed = 1'b0;
  logic [AW-1:0] fault_addr = '0;

  // memory model: responds on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack || mem_fault) begin
        mem_ack   = 1'b0;
        mem_fault = 1'b0;
      end else if (mem_req) begin
        if (fault_armed && mem_we && mem_addr == fault_addr) begin
          mem_fault   = 1'b1;
          fault_armed = 1'b0;
        end else begin
          mem_ack  = 1'b1;
          n_access = n_access + 1;
          if (mem_we) mem[int'(mem_addr) % MEM_N] = mem_wdata;
          else        mem_rdata = mem[int'(mem_addr) % MEM_N];
        end
      end
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill_mem(input int seed);
    for (int i = 0; i < MEM_N; i++) begin
      mem[i]  = WW'(i * 40503 + seed * 977) ^ WW'(seed << 4);
      gold[i] = mem[i];
    end
  endtask

  function automatic logic [3:0] nib(input logic [WW-1:0] wd, input int idx);
    return wd[WW-1-4*idx -: 4];
  endfunction

  // golden image from the address, nibble and phase rules
  task automatic golden(input vec_t v);
    for (int l = int'(v.h); l >= 1; l--) begin
      int first;
      first = (l == int'(v.h) && v.rs != 0) ? int'(v.w) - int'(v.rs) : 0;
      for (int c = first; c < int'(v.w); c++) begin
        int sxp, dxp, sa, da;
        logic [3:0] s, d, r;
        logic [1:0] ph;
        sxp = int'(v.sx) + c;
        dxp = int'(v.dx) + c;
        sa  = SB + (SH - (int'(v.sy) + l)) * SR + sxp / 4;
        da  = DB + (DH - (int'(v.dy) + l)) * DR + dxp / 4;
        s   = nib(gold[sa], sxp % 4);
        d   = nib(gold[da], dxp % 4);
        ph  = {1'(int'(v.dy) + l - 1), 1'(dxp)};
        r   = comb_f(s, d, ph);
        gold[da][WW-1-4*(dxp%4) -: 4] = r;
      end
    end
  endtask

  function automatic int mem_diffs();
    int n = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== gold[i]) n++;
    return n;
  endfunction

  task automatic drive(input vec_t v);
    src_x = v.sx; src_y = v.sy; dst_x = v.dx; dst_y = v.dy;
    xfer_w = v.w; xfer_h = v.h; resume_w = v.rs;
  endtask

  // 1 done, 2 error, 3 suspended, 0 timeout
  task automatic run(output int st);
    st = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (done)      begin st = 1; break; end
      if (error)     begin st = 2; break; end
      if (suspended) begin st = 3; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int st, d;
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check(!busy && !done && !error && !suspended && !mem_req, "R1 reset",
          int'({busy, done, error, suspended, mem_req}), 0);

    // table of vectors: R2..R9 via rejection and golden images
    for (int i = 0; i < NVEC; i++) begin
      fill_mem(i + 1);
      drive(VECS[i]);
      n_access = 0;
      if (!VECS[i].bad) golden(VECS[i]);
      run(st);
      if (VECS[i].bad) begin
        check(st == 2 && n_access == 0, "R3 R4 reject", st * 1000 + n_access, 2000);
      end else begin
        d = mem_diffs();
        check(st == 1 && d == 0, "R5 R6 R7 R8 image", st * 1000 + d, 1000);
        check(lines_left == 0, "R9 lines", int'(lines_left), 0);
      end
      repeat (2) @(negedge clk);
    end

    // R2: wrong pixel format on either side
    fill_mem(20);
    drive(VECS[1]);
    src_bpp = 4'd8; n_access = 0;
    run(st);
    check(st == 2 && n_access == 0, "R2 src bpp", st * 1000 + n_access, 2000);
    src_bpp = 4'd4; dst_bpp = 4'd1; n_access = 0;
    run(st);
    check(st == 2 && n_access == 0, "R2 dst bpp", st * 1000 + n_access, 2000);
    dst_bpp = 4'd4;
    check(mem_diffs() == 0, "R2 mem untouched", mem_diffs(), 0);

    // R1: start while busy has no effect
    fill_mem(21);
    v = VECS[0];
    drive(v);
    golden(v);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    xfer_h = '0; src_x = 8'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    st = 0;
    for (int k = 0; k < 20000; k++) begin
      if (done)  begin st = 1; break; end
      if (error) begin st = 2; break; end
      @(negedge clk);
    end
    d = mem_diffs();
    check(st == 1 && d == 0, "R1 start ignored", st * 1000 + d, 1000);

    // R10: interrupt between lines, then resume from the line count
    fill_mem(22);
    v = VECS[1];
    drive(v);
    golden(v);
    irq = 1'b1;
    run(st);
    irq = 1'b0;
    check(st == 3, "R10 suspend", st, 3);
    check(lines_left == 8'd2 && resume_width == 0, "R10 counts",
          int'(lines_left) * 1000 + int'(resume_width), 2000);
    xfer_h = lines_left; resume_w = resume_width;
    run(st);
    d = mem_diffs();
    check(st == 1 && d == 0, "R10 resumed image", st * 1000 + d, 1000);

    // R11: fault on second destination word write of first line
    fill_mem(23);
    v = '{8'd1, 8'd2, 8'd2, 8'd1, 8'd7, 8'd3, 8'd0, 1'b0};
    drive(v);
    golden(v);
    fault_addr = AW'(DB + (DH - (1 + 3)) * DR + 1);
    fault_armed = 1'b1;
    run(st);
    check(st == 3, "R11 suspend", st, 3);
    check(lines_left == 8'd3 && resume_width == 8'd5, "R11 counts",
          int'(lines_left) * 1000 + int'(resume_width), 3005);
    @(negedge clk);
    check(!mem_req && !busy, "R11 quiet", int'({mem_req, busy}), 0);
    xfer_h = lines_left; resume_w = resume_width;
    run(st);
    d = mem_diffs();
    check(st == 1 && d == 0, "R11 resumed image", st * 1000 + d, 1000);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule